// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block derives the clock that is sent to an SD/MMC card from the host's master clock. A control word sets an even division ratio, a bypass that forwards the master clock unchanged, a master enable, and two conditions under which the clock is parked: an idle bus (power saving) and a stalled data FIFO (flow control). The card clock only ever stops in its low phase, and a new ratio is taken up at a falling edge. No pulse is ever cut short.

Next to the card clock, the block drives a one-master-cycle strobe for each rising and each falling card-clock edge. The command and data shifters use these strobes to advance in the master clock domain without sampling the card clock itself. The block also decodes the two bus-width flags into a width code for the data path.

Top module: `cardclk_gen`

## Requirements
- R1: With bypass clear and the clock running, every card-clock period is 2*(N+1) master cycles: N+1 high followed by N+1 low, where N is the divide input.
- R2: The divide input is 8 bits wide by default. N = 255 gives the longest period, 512 master cycles (256 high, 256 low), and N = 0 gives the shortest, 2 cycles.
- R3: With bypass set and the clock not stopped, the card clock follows the master clock (high in the master high phase, low in its low phase), the divide input has no effect, and both strobes are high on every master cycle.
- R4: With the enable clear, the card clock finishes any high phase in progress and then stays low with no strobes. When the enable is set again, the clock resumes.
- R5: With power-save set and the bus-idle input high, the card clock is parked low. Bus-idle has no effect while power-save is clear.
- R6: With flow control set, a high transmit-empty or receive-full input parks the card clock low. With flow control clear, both inputs have no effect.
- R7: The bus width code is 0 for 1 bit, 1 for 4 bits and 2 for 8 bits. The 8-bit flag wins when both flags are set.
- R8: A divide value that changes during a high phase does not alter that phase. It governs every phase from the next falling edge onward.
- R9: The rise strobe is high for exactly the first master cycle in which the card clock is high. The fall strobe is high for exactly the first master cycle in which it is low.
- R10: During and right after reset, the card clock and both strobes are low and the width code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_n_i | input | DIV_W | Divide value N; ratio is 2*(N+1) |
| clk_en_i | input | 1 | Card clock enable |
| bypass_i | input | 1 | Forward the master clock undivided |
| pwr_save_i | input | 1 | Park the clock while the bus is idle |
| flow_en_i | input | 1 | Park the clock on FIFO stall |
| bus4_i | input | 1 | 4-bit bus flag |
| bus8_i | input | 1 | 8-bit bus flag |
| bus_idle_i | input | 1 | Shifters report an idle bus |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| card_clk_o | output | 1 | Card clock |
| rise_stb_o | output | 1 | Marks the first master cycle of each high phase |
| fall_stb_o | output | 1 | Marks the first master cycle of each low phase |
| bus_width_o | output | 2 | Width code for the data path |

## Verification
The hardest case to reach is a ratio change that lands inside a high phase. The old phase length must be kept while the new ratio governs the low phase that follows, so the two phases next to the falling edge have different lengths. The stimulus waits for a rise strobe, changes the divide value in that same master cycle, and then counts both phase lengths. The same edge-synchronised approach is used when leaving bypass, so that the hand-back from the forwarded master clock to the divider is observed with no overlapping pulse.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
   typedef enum logic [1:0] {
      BUS_W1 = 2'b00,
      BUS_W4 = 2'b01,
      BUS_W8 = 2'b10
   } bus_width_e;
endpackage

// File: rtl/cardclk_cfg.sv
module cardclk_cfg
   import cardclk_pkg::*;
(
   input  logic       clk_en_i,
   input  logic       pwr_save_i,
   input  logic       flow_en_i,
   input  logic       bus4_i,
   input  logic       bus8_i,
   input  logic       bus_idle_i,
   input  logic       tx_empty_i,
   input  logic       rx_full_i,
   output logic       stop_o,
   output bus_width_e width_o
);
   logic idle_park, fifo_park;

   always_comb begin
      idle_park = pwr_save_i & bus_idle_i;
      fifo_park = flow_en_i & (tx_empty_i | rx_full_i);
      stop_o    = ~clk_en_i | idle_park | fifo_park;
   end

   // the wider flag takes precedence
   always_comb begin
      if (bus8_i)      width_o = BUS_W8;
      else if (bus4_i) width_o = BUS_W4;
      else             width_o = BUS_W1;
   end
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] ratio_i,
   input  logic             hold_i,
   output logic             lvl_o,
   output logic             rise_o,
   output logic             fall_o
);
   logic [DIV_W-1:0] cnt_q, lim_q;
   logic             terminal;

   assign terminal = (cnt_q == lim_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         lim_q  <= '0;
         lvl_o  <= 1'b0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else begin
         rise_o <= 1'b0;
         fall_o <= 1'b0;
         if (lvl_o) begin
            // a high phase always completes; the new limit is taken at the fall
            if (terminal) begin
               lvl_o  <= 1'b0;
               cnt_q  <= '0;
               lim_q  <= ratio_i;
               fall_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (hold_i) begin
            cnt_q <= '0;
            lim_q <= ratio_i;
         end else if (terminal) begin
            lvl_o  <= 1'b1;
            cnt_q  <= '0;
            rise_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   a_r9_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> (lvl_o && !$past(lvl_o)));
   a_r9_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |-> (!lvl_o && $past(lvl_o)));
   a_r4_no_rise_when_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lvl_o) |-> !$past(hold_i));
   a_r8_limit_fixed_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_o && $past(lvl_o)) |-> $stable(lim_q));
   a_r1_count_within_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_o |-> (cnt_q <= lim_q));
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
   import cardclk_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_n_i,
   input  logic             clk_en_i,
   input  logic             bypass_i,
   input  logic             pwr_save_i,
   input  logic             flow_en_i,
   input  logic             bus4_i,
   input  logic             bus8_i,
   input  logic             bus_idle_i,
   input  logic             tx_empty_i,
   input  logic             rx_full_i,
   output logic             card_clk_o,
   output logic             rise_stb_o,
   output logic             fall_stb_o,
   output logic [1:0]       bus_width_o
);
   localparam int RATIO_MAX = 2 * (1 << DIV_W);

   generate
      if (DIV_W < 1 || RATIO_MAX > 131072) begin : g_bad_width
         $error("cardclk_gen: DIV_W out of supported range");
      end
   endgenerate

   logic       stop, div_hold, div_lvl, div_rise, div_fall;
   logic       gate_q;
   bus_width_e width;

   cardclk_cfg u_cfg (
      .clk_en_i   (clk_en_i),
      .pwr_save_i (pwr_save_i),
      .flow_en_i  (flow_en_i),
      .bus4_i     (bus4_i),
      .bus8_i     (bus8_i),
      .bus_idle_i (bus_idle_i),
      .tx_empty_i (tx_empty_i),
      .rx_full_i  (rx_full_i),
      .stop_o     (stop),
      .width_o    (width)
   );

   // divider parks low while stopped, bypassed, or while the bypass gate is open
   assign div_hold = stop | bypass_i | gate_q;

   cardclk_div #(.DIV_W(DIV_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ratio_i (div_n_i),
      .hold_i  (div_hold),
      .lvl_o   (div_lvl),
      .rise_o  (div_rise),
      .fall_o  (div_fall)
   );

   // bypass gate changes only while the master clock is low
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q <= 1'b0;
      else         gate_q <= bypass_i & ~stop & ~div_lvl;
   end

   assign card_clk_o  = div_lvl | (clk_i & gate_q);
   assign rise_stb_o  = div_rise | gate_q;
   assign fall_stb_o  = div_fall | gate_q;
   assign bus_width_o = width;

   a_r3_gate_excludes_divider: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_q |-> !div_lvl);
   a_r4_stop_blocks_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop && !div_lvl) |=> !div_lvl);
endmodule

// File: tb/cardclk_gen_test.sv
`timescale 1ns/1ps
module cardclk_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_n = 8'd3;
   logic       clk_en = 1'b0, bypass = 1'b0, pwr_save = 1'b0, flow_en = 1'b0;
   logic       bus4 = 1'b0, bus8 = 1'b0, bus_idle = 1'b0, tx_empty = 1'b0, rx_full = 1'b0;
   logic       card_clk, rise_stb, fall_stb;
   logic [1:0] bus_width;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cardclk_gen uut (
      .clk_i(clk), .rst_ni(rst_n), .div_n_i(div_n), .clk_en_i(clk_en),
      .bypass_i(bypass), .pwr_save_i(pwr_save), .flow_en_i(flow_en),
      .bus4_i(bus4), .bus8_i(bus8), .bus_idle_i(bus_idle),
      .tx_empty_i(tx_empty), .rx_full_i(rx_full),
      .card_clk_o(card_clk), .rise_stb_o(rise_stb), .fall_stb_o(fall_stb),
      .bus_width_o(bus_width)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // sample point: half a nanosecond after the falling master edge
   task automatic tick();
      @(negedge clk);
      #0.5;
   endtask

   // sync to a rise strobe, optionally change N in that cycle, count both phases
   task automatic measure(input int new_div, output int hi, output int lo);
      int t = 0;
      tick();
      while (!rise_stb && t < 3000) begin tick(); t++; end
      check(card_clk === 1'b1, "R9 rise strobe on first high cycle", card_clk, 1);
      if (new_div >= 0) div_n = new_div[7:0];
      hi = 1;
      tick();
      while (card_clk && hi < 600) begin hi++; tick(); end
      check(fall_stb === 1'b1, "R9 fall strobe on first low cycle", fall_stb, 1);
      lo = 1;
      tick();
      while (!card_clk && lo < 600) begin lo++; tick(); end
   endtask

   task automatic expect_period(input int n, input string req);
      int hi, lo;
      div_n = n[7:0];
      measure(-1, hi, lo);
      measure(-1, hi, lo);
      check(hi == n + 1, req, hi, n + 1);
      check(lo == n + 1, req, lo, n + 1);
   endtask

   task automatic expect_parked(input string req, input int cycles);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         tick();
         if (card_clk || rise_stb || fall_stb) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   task automatic t_reset();
      #1;
      check(card_clk == 1'b0 && rise_stb == 1'b0 && fall_stb == 1'b0, "R10 outputs low in reset",
            {card_clk, rise_stb, fall_stb}, 0);
      check(bus_width == 2'd0, "R10 width code in reset", bus_width, 0);
      tick(); tick();
      rst_n = 1'b1;
      tick();
      check(card_clk == 1'b0 && rise_stb == 1'b0, "R10 low after reset", card_clk, 0);
   endtask

   task automatic t_divide();
      clk_en = 1'b1;
      expect_period(3, "R1 ratio N=3");
      expect_period(6, "R1 ratio N=6");
      expect_period(0, "R2 smallest ratio N=0");
   endtask

   task automatic t_max();
      expect_period(255, "R2 largest ratio N=255");
   endtask

   task automatic t_change();
      int hi, lo;
      expect_period(3, "R8 baseline N=3");
      measure(9, hi, lo);
      check(hi == 4, "R8 high phase keeps old ratio", hi, 4);
      check(lo == 10, "R8 new ratio from falling edge", lo, 10);
      measure(-1, hi, lo);
      check(hi == 10, "R8 new ratio sustained", hi, 10);
   endtask

   task automatic t_enable();
      div_n = 8'd3;
      tick(); tick(); tick(); tick(); tick(); tick(); tick(); tick(); tick(); tick();
      clk_en = 1'b0;
      repeat (6) tick();
      expect_parked("R4 enable clear parks low", 40);
      clk_en = 1'b1;
      expect_period(3, "R4 resumes after enable");
   endtask

   task automatic t_psave();
      pwr_save = 1'b0; bus_idle = 1'b1;
      expect_period(3, "R5 idle ignored without power-save");
      pwr_save = 1'b1;
      repeat (6) tick();
      expect_parked("R5 power-save parks on idle bus", 30);
      bus_idle = 1'b0;
      expect_period(3, "R5 runs when bus busy");
      pwr_save = 1'b0;
   endtask

   task automatic t_flow();
      flow_en = 1'b0; tx_empty = 1'b1; rx_full = 1'b1;
      expect_period(3, "R6 FIFO flags ignored without flow control");
      tx_empty = 1'b0; rx_full = 1'b0; flow_en = 1'b1;
      expect_period(3, "R6 runs with no stall");
      tx_empty = 1'b1;
      repeat (6) tick();
      expect_parked("R6 transmit empty stalls", 30);
      tx_empty = 1'b0; rx_full = 1'b1;
      repeat (2) tick();
      expect_parked("R6 receive full stalls", 30);
      rx_full = 1'b0;
      expect_period(3, "R6 resumes after stall");
      flow_en = 1'b0;
   endtask

   task automatic t_width();
      bus4 = 1'b0; bus8 = 1'b0; #1;
      check(bus_width == 2'd0, "R7 one-bit width", bus_width, 0);
      bus4 = 1'b1; #1;
      check(bus_width == 2'd1, "R7 four-bit width", bus_width, 1);
      bus4 = 1'b0; bus8 = 1'b1; #1;
      check(bus_width == 2'd2, "R7 eight-bit width", bus_width, 2);
      bus4 = 1'b1; #1;
      check(bus_width == 2'd2, "R7 eight-bit flag wins", bus_width, 2);
      bus4 = 1'b0; bus8 = 1'b0;
   endtask

   task automatic t_bypass();
      int bad_hi = 0, bad_lo = 0, bad_stb = 0;
      div_n = 8'd7;
      bypass = 1'b1;
      repeat (12) tick();
      for (int i = 0; i < 10; i++) begin
         @(posedge clk); #1;
         if (card_clk !== 1'b1) bad_hi++;
         @(negedge clk); #1;
         if (card_clk !== 1'b0) bad_lo++;
         if (!(rise_stb && fall_stb)) bad_stb++;
      end
      check(bad_hi == 0, "R3 bypass high with master clock", bad_hi, 0);
      check(bad_lo == 0, "R3 bypass low with master clock", bad_lo, 0);
      check(bad_stb == 0, "R3 bypass strobes every cycle", bad_stb, 0);
      clk_en = 1'b0;
      repeat (3) tick();
      expect_parked("R4 enable clear stops bypass", 10);
      clk_en = 1'b1;
      bypass = 1'b0;
      expect_period(2, "R3 divider back after bypass");
   endtask

   initial begin
      t_reset();
      t_divide();
      t_max();
      t_change();
      t_enable();
      t_psave();
      t_flow();
      t_width();
      t_bypass();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #750000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule